// File: doc/BRIEF.md
# Key-Sequence Register Write Guard

This block stands between a peripheral's register bus and its configuration registers. Every bus write is presented to it as a strobe, a word address and a data word. From these it produces a permit strobe that lets the write reach the addressed register. Writes to the protected configuration registers go through only while the guard is open. Those registers are time, date, control, clock divider and alarm. Other registers, such as the flag register that software clears, are always writable.

The guard opens when software writes two fixed key words to a dedicated key address. The first key must come before the second, and no other write may fall between them. Any other word written to the key address closes the guard at once. The usual sequence is to open the guard, reconfigure, then write a junk word to the key address to close it again. The key address is not a real register. The guard flags reads of that address so that the read mux returns zero.

Top module: `wp_key_gate`

## Requirements
- R1: While reset is asserted, and after it is released, the guard is closed (`locked` = 1).
- R2: A write of 0x000000CA to key address 0x24, followed by a write of 0x00000053 to 0x24 with no other write between, opens the guard. `locked` goes to 0 in the cycle after the second write.
- R3: A write to a protected address (0x00, 0x04, 0x08, 0x10, 0x1C) raises `wr_permit` in the same cycle only while the guard is open. While it is closed, the write is dropped.
- R4: Writing any word to the key address other than the two keys closes the guard from the next cycle. This includes 0x000000FF and 0x00000153, because the whole data word is compared.
- R5: A second-key write that does not directly follow a first-key write leaves the guard closed.
- R6: A write to any other address between the first and second key aborts the sequence, and the later second key does not open the guard.
- R7: A write to an address that is neither protected nor the key address, such as 0x0C, raises `wr_permit` in the same cycle whether the guard is open or closed.
- R8: A write to the key address never raises `wr_permit`.
- R9: `rd_key_zero` is 1 exactly when `rd_addr` equals the key address, so that the read returns zero.
- R10: A first-key write while the guard is open closes it and arms a new sequence. Repeated first-key writes keep the sequence armed, and a following second key opens the guard.
- R11: Cycles with no write between the two keys do not abort the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| wr_permit | output | 1 | Write may update the addressed register |
| locked | output | 1 | Guard closed |
| rd_key_zero | output | 1 | Read hits the key address; return zero |

## Verification
`wr_permit` and `rd_key_zero` are combinational. They are due in the cycle in which the write or read is presented. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. `locked` follows the state register, so it changes one rising edge after the key write. The bench reads it 1 ns after that edge. After `rst_n` rises, the reset synchronizer holds the guard in reset for two more rising edges, and the bench waits past them before it applies any stimulus.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;

  typedef enum logic [1:0] {
    WPG_LOCKED = 2'd0,
    WPG_ARMED  = 2'd1,
    WPG_OPEN   = 2'd2
  } wpg_state_e;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
  parameter int                   AW        = 8,
  parameter int                   NPROT     = 5,
  parameter logic [NPROT*AW-1:0]  PROT_LIST = '0,
  parameter logic [AW-1:0]        KEY_ADDR  = '0
) (
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          prot_hit,
  output logic          key_hit,
  output logic          rd_key_hit
);

  logic [NPROT-1:0] entry_hit;

  for (genvar gi = 0; gi < NPROT; gi++) begin : g_prot_cmp
    localparam logic [AW-1:0] ENTRY = PROT_LIST[gi*AW +: AW];
    assign entry_hit[gi] = (wr_addr == ENTRY);
  end

  assign prot_hit   = |entry_hit;
  assign key_hit    = (wr_addr == KEY_ADDR);
  assign rd_key_hit = (rd_addr == KEY_ADDR);

endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_gate_pkg::*;
#(
  parameter int              DW   = 32,
  parameter logic [DW-1:0]   KEY1 = '0,
  parameter logic [DW-1:0]   KEY2 = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          other_wr,
  input  logic [DW-1:0] wr_data,
  output logic          unlocked
);

  wpg_state_e state_q;
  wpg_state_e state_d;
  logic       state_en;

  assign state_en = key_wr | other_wr;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      if (wr_data == KEY1) begin
        state_d = WPG_ARMED;
      end else if ((wr_data == KEY2) && (state_q == WPG_ARMED)) begin
        state_d = WPG_OPEN;
      end else begin
        state_d = WPG_LOCKED;
      end
    end else if (other_wr && (state_q == WPG_ARMED)) begin
      state_d = WPG_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WPG_LOCKED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign unlocked = (state_q == WPG_OPEN);

  // R6
  abort_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WPG_ARMED) && other_wr && !key_wr |=> (state_q == WPG_LOCKED));

  // R11
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr && !other_wr |=> $stable(state_q));

endmodule

// File: rtl/wp_key_gate.sv
module wp_key_gate #(
  parameter int                  AW        = 8,
  parameter int                  DW        = 32,
  parameter int                  KW        = 8,
  parameter int                  NPROT     = 5,
  parameter logic [NPROT*AW-1:0] PROT_LIST = {8'h1C, 8'h10, 8'h08, 8'h04, 8'h00},
  parameter logic [AW-1:0]       KEY_ADDR  = 8'h24,
  parameter logic [KW-1:0]       KEY_FIRST = 8'hCA,
  parameter logic [KW-1:0]       KEY_SECOND = 8'h53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          wr_permit,
  output logic          locked,
  output logic          rd_key_zero
);

  localparam logic [DW-1:0] K1W = {{(DW-KW){1'b0}}, KEY_FIRST};
  localparam logic [DW-1:0] K2W = {{(DW-KW){1'b0}}, KEY_SECOND};

  logic rst_sync_n;
  logic prot_hit;
  logic key_hit;
  logic unlocked;
  logic key_wr;
  logic other_wr;

  wp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wp_addr_decode #(
    .AW        (AW),
    .NPROT     (NPROT),
    .PROT_LIST (PROT_LIST),
    .KEY_ADDR  (KEY_ADDR)
  ) u_decode (
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .prot_hit   (prot_hit),
    .key_hit    (key_hit),
    .rd_key_hit (rd_key_zero)
  );

  assign key_wr   = wr_en & key_hit;
  assign other_wr = wr_en & ~key_hit;

  wp_key_fsm #(
    .DW   (DW),
    .KEY1 (K1W),
    .KEY2 (K2W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .key_wr   (key_wr),
    .other_wr (other_wr),
    .wr_data  (wr_data),
    .unlocked (unlocked)
  );

  assign wr_permit = wr_en & ~key_hit & (~prot_hit | unlocked);
  assign locked    = ~unlocked;

  // R1
  reset_closed_chk: assert property (@(posedge clk)
    !rst_sync_n |=> locked);

  // R2
  pair_opens_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && key_hit && wr_data == K2W) &&
    $past(wr_en && key_hit && wr_data == K1W) |=> !locked);

  // R3
  closed_blocks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked && wr_en && prot_hit |-> !wr_permit);

  // R4
  wrong_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && key_hit && (wr_data != K1W) && (wr_data != K2W) |=> locked);

  // R5
  closed_holds_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked && !(wr_en && key_hit && wr_data == K2W) |=> locked);

  // R7
  free_addr_passes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && !prot_hit && !key_hit |-> wr_permit);

  // R8
  key_never_passes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && key_hit |-> !wr_permit);

endmodule

// File: tb/wp_key_gate_tb.sv
`timescale 1ns/1ps
module wp_key_gate_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic        wr_permit;
  logic        locked;
  logic        rd_key_zero;

  int checks = 0;
  int fails  = 0;

  wp_key_gate u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .wr_permit   (wr_permit),
    .locked      (locked),
    .rd_key_zero (rd_key_zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // vector: {en, addr, data, exp_permit, exp_locked_after, req}
  localparam int NV = 22;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0001, 1'b0, 1'b1, 4'd3},  // R3 closed drops
    {1'b1, 8'h0C, 32'h0000_0000, 1'b1, 1'b1, 4'd7},  // R7 flag clear while closed
    {1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b1, 4'd5},  // R5 lone second key
    {1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b1, 4'd2},  // R2 first key
    {1'b0, 8'h24, 32'h0000_0000, 1'b0, 1'b1, 4'd11}, // R11 idle gap
    {1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b0, 4'd2},  // R2 second key opens
    {1'b1, 8'h08, 32'h0000_0040, 1'b1, 1'b0, 4'd3},  // R3 open passes
    {1'b1, 8'h0C, 32'h0000_0000, 1'b1, 1'b0, 4'd7},  // R7 open passes
    {1'b1, 8'h1C, 32'h1234_5678, 1'b1, 1'b0, 4'd3},  // R3
    {1'b1, 8'h24, 32'h0000_00FF, 1'b0, 1'b1, 4'd4},  // R4 junk closes (R8 no permit)
    {1'b1, 8'h10, 32'h0000_00FF, 1'b0, 1'b1, 4'd4},  // R4 dropped after close
    {1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b1, 4'd6},  // R6 arm
    {1'b1, 8'h0C, 32'h0000_0001, 1'b1, 1'b1, 4'd6},  // R6 intruding write
    {1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b1, 4'd6},  // R6 stays closed
    {1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b1, 4'd10}, // R10 arm
    {1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b1, 4'd10}, // R10 re-arm
    {1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b0, 4'd10}, // R10 opens
    {1'b1, 8'h24, 32'h0000_00CA, 1'b0, 1'b1, 4'd10}, // R10 first key closes
    {1'b1, 8'h24, 32'h0000_0053, 1'b0, 1'b0, 4'd10}, // R10 reopens
    {1'b1, 8'h04, 32'h0000_0099, 1'b1, 1'b0, 4'd3},  // R3
    {1'b1, 8'h24, 32'h0000_0153, 1'b0, 1'b1, 4'd4},  // R4 full word compare
    {1'b1, 8'h04, 32'h0000_0099, 1'b0, 1'b1, 4'd3}   // R3
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got %0h expected %0h", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(locked === 1'b1, "R1", {31'd0, locked}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(locked === 1'b1, "R1", {31'd0, locked}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      string rq;
      v  = VEC[i];
      rq = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      wr_en = v[46]; wr_addr = v[45:38]; wr_data = v[37:6];
      #1;
      chk(wr_permit === v[5], rq, {31'd0, wr_permit}, {31'd0, v[5]});
      @(posedge clk);
      #1;
      chk(locked === v[4], rq, {31'd0, locked}, {31'd0, v[4]});
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R8: key writes never permitted, even while open
    do_write(8'h24, 32'h0000_00CA);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h0000_0053;
    #1;
    chk(wr_permit === 1'b0, "R8", {31'd0, wr_permit}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk(locked === 1'b0, "R2", {31'd0, locked}, 32'd0);

    // R9: key address read is flagged for zero
    rd_addr = 8'h24;
    #1;
    chk(rd_key_zero === 1'b1, "R9", {31'd0, rd_key_zero}, 32'd1);
    rd_addr = 8'h20;
    #1;
    chk(rd_key_zero === 1'b0, "R9", {31'd0, rd_key_zero}, 32'd0);
    rd_addr = 8'h0C;
    #1;
    chk(rd_key_zero === 1'b0, "R9", {31'd0, rd_key_zero}, 32'd0);

    // R1: reset while open closes the guard
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(locked === 1'b1, "R1", {31'd0, locked}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(locked === 1'b1, "R1", {31'd0, locked}, 32'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h7F;
    #1;
    chk(wr_permit === 1'b0, "R3", {31'd0, wr_permit}, 32'd0);
    @(negedge clk);
    wr_en = 1'b0;

    finish_run();
  end

endmodule